// File: doc/BRIEF.md
# Programmable Clock Output Path

This block turns one of two incoming clocks into a single gated clock output. A select bit picks either the synthesized clock or the reference oscillator clock. A 3-bit code `k` then divides the chosen clock by 2^k, for ratios from 1 to 128. The two source choices and eight ratios give sixteen output settings. The divided clock drives `clk_out`. The output is turned off when `oe` is low or when `pwr_dn` is high, and it stays low while off.

A mode bit sets how turning off and turning on behave relative to the output waveform. In asynchronous mode the gate follows the controls at once, through a combinational path only. In synchronous mode the gate changes only while the divided clock is low, so the output never shows a shortened high pulse.

Power-down also clears the divider once the gate has closed. After release, the output therefore starts from a known phase. The system changes the configuration inputs only while the output is off.

Top module: `clkout_path`

## Requirements
- R1: With divide code k (0..7), `clk_out` has a period of exactly 2^k periods of the selected source while enabled; k=0 passes the source through.
- R2: For k of 1 or more, each `clk_out` high phase lasts 2^(k-1) source periods (50% duty). For k=0 it equals the source's own high time.
- R3: `cfg_src_sel`=0 selects `pll_clk` and `cfg_src_sel`=1 selects `osc_clk` as the divider input.
- R4: While `oe` is low, `clk_out` stays low in either mode, once the synchronous-mode gate has closed.
- R5: With `pwr_dn` high, `clk_out` is low and the divider is held cleared. After `pwr_dn` falls in asynchronous mode with k of 1 or more, the first `clk_out` rising edge occurs on the 2^(k-1)-th source rising edge.
- R6: In asynchronous mode (`cfg_sync_mode`=0), dropping `oe` while `clk_out` is high forces `clk_out` low immediately, with no clock edge needed.
- R7: In synchronous mode (`cfg_sync_mode`=1), dropping `oe` during a high phase lets that high phase complete at full length, and no later high phase follows.
- R8: In synchronous mode, the first high phase after `oe` rises has the full length given in R2.
- R9: While `rst_n` is low, `clk_out` is low whatever the other inputs are.
- R10: In synchronous mode, raising `pwr_dn` during a high phase lets that phase complete at full length before the output stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pll_clk | input | 1 | Synthesized clock source |
| osc_clk | input | 1 | Reference oscillator clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src_sel | input | 1 | Source select: 0 synthesized, 1 oscillator |
| cfg_div_code | input | 3 | Divide code k, ratio 2^k |
| cfg_sync_mode | input | 1 | 1 = gate changes only in low phase, 0 = immediate |
| oe | input | 1 | Output enable, active high |
| pwr_dn | input | 1 | Power-down, active high |
| clk_out | output | 1 | Divided, gated clock output |

## Verification
The hardest case is a control change that lands inside a high phase of a slow divided clock. Only in that case does synchronous gating differ from a plain AND gate. To produce it, the bench waits for a rising edge of `clk_out`, moves `oe` or `pwr_dn` a fraction of a nanosecond later, and then times the falling edge against the full high time. Randomized rounds choose the source, the code, the mode and the enable offset from a fixed seed. Directed rounds cover the restart phase after power-down and the extreme codes 0 and 7.

// File: rtl/clkout_path.sv
module clkout_path #(
  parameter int DIV_BITS = 7,
  localparam int CW = $clog2(DIV_BITS + 1)
) (
  input  logic          pll_clk,
  input  logic          osc_clk,
  input  logic          rst_n,
  input  logic          cfg_src_sel,
  input  logic [CW-1:0] cfg_div_code,
  input  logic          cfg_sync_mode,
  input  logic          oe,
  input  logic          pwr_dn,
  output logic          clk_out
);

  logic                sel_clk;
  logic [DIV_BITS-1:0] cnt;
  logic                div_o;
  logic                div_low;
  logic                en_req;
  logic                en_q;
  logic                gate;
  logic                cnt_clr;

  assign sel_clk = cfg_src_sel ? osc_clk : pll_clk;
  assign en_req  = oe & ~pwr_dn;
  assign gate    = rst_n & (cfg_sync_mode ? en_q : en_req);
  assign cnt_clr = ~rst_n | (pwr_dn & ~gate);

  always_ff @(posedge sel_clk or posedge cnt_clr)
    if (cnt_clr) cnt <= '0;
    else         cnt <= cnt + 1'b1;

  always_comb begin
    div_o = sel_clk;
    for (int i = 1; i <= DIV_BITS; i++)
      if (int'(cfg_div_code) == i) div_o = cnt[i-1];
  end

  assign div_low = (cfg_div_code == '0) | ~div_o;

  always_ff @(negedge sel_clk or negedge rst_n)
    if (!rst_n)       en_q <= 1'b0;
    else if (div_low) en_q <= en_req;

  assign clk_out = div_o & gate;

  p_async_off_r4: assert property (@(posedge sel_clk) disable iff (!rst_n)
    (!oe && !cfg_sync_mode) |-> !clk_out);

  p_pd_clear_r5: assert property (@(posedge sel_clk) disable iff (!rst_n)
    (pwr_dn && !gate) |-> (cnt == '0));

  p_count_step_r1: assert property (@(posedge sel_clk) disable iff (cnt_clr)
    1'b1 |=> (cnt == $past(cnt) + 1'b1));

  p_gate_hold_r7: assert property (@(negedge sel_clk) disable iff (!rst_n)
    (cfg_div_code != '0 && div_o) |=> $stable(en_q));

  always_comb
    if (!rst_n) p_reset_low_r9: assert (!clk_out);

endmodule

// File: tb/clkout_path_bench.sv
`timescale 1ns/1ps
module clkout_path_bench;
  logic pll_clk = 0, osc_clk = 0;
  logic rst_n = 0, src = 0, sync_m = 0, oe = 0, pd = 0;
  logic [2:0] code = 0;
  logic clk_out;
  int total = 0, bad = 0;

  localparam real TPLL = 5.0;
  localparam real TOSC = 14.0;

  always #2.5 pll_clk = ~pll_clk;
  always #7.0 osc_clk = ~osc_clk;

  clkout_path u_clkout_path (
    .pll_clk(pll_clk), .osc_clk(osc_clk), .rst_n(rst_n),
    .cfg_src_sel(src), .cfg_div_code(code), .cfg_sync_mode(sync_m),
    .oe(oe), .pwr_dn(pd), .clk_out(clk_out));

  function automatic real tsrc(logic s);
    return s ? TOSC : TPLL;
  endfunction
  function automatic real exp_period(logic s, int k);
    return real'(1 << k) * tsrc(s);
  endfunction
  function automatic real exp_high(logic s, int k);
    return (k == 0) ? tsrc(s) / 2.0 : real'(1 << (k - 1)) * tsrc(s);
  endfunction

  task automatic check(bit ok, string req, real act, real expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, expv);
    end
  endtask

  task automatic check_low_for(real span, string req);
    int highs = 0;
    for (real t = 0.0; t < span; t += 1.3) begin
      #1.3;
      if (clk_out) highs++;
    end
    check(highs == 0, req, real'(highs), 0.0);
  endtask

  task automatic disable_and_config(logic s, int k, logic m);
    oe = 0;
    #(2.0 * exp_period(src, int'(code)) + 30.0);
    src = s; code = 3'(k); sync_m = m;
    #3.1;
  endtask

  initial begin
    #900000;
    total++; bad++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    real t0, t1, t2;
    void'($urandom(1234));
    // R9: reset holds the output low even with pass-through enabled
    oe = 1; code = 0; sync_m = 0;
    #1.1;
    check_low_for(40.0, "R9 reset low");
    rst_n = 1;
    #0.7;
    oe = 0;

    // R1 R2 R3 R8: random rounds plus the corner codes 0 and 7
    for (int it = 0; it < 24; it++) begin
      logic s, m;
      int k;
      s = 1'($urandom % 2);
      k = int'($urandom % 8);
      m = 1'($urandom % 2);
      if (it == 0) begin s = 0; k = 0; end
      if (it == 1) begin s = 1; k = 7; end
      if (it == 2) begin s = 1; k = 0; m = 1; end
      disable_and_config(s, k, m);
      #(real'($urandom % 50) + 0.37);
      oe = 1;
      @(posedge clk_out); t0 = $realtime;
      @(negedge clk_out); t1 = $realtime;
      if (m) check((t1 - t0) > exp_high(s, k) - 0.01 && (t1 - t0) < exp_high(s, k) + 0.01,
                   "R8 first high full", t1 - t0, exp_high(s, k));
      @(posedge clk_out); t0 = $realtime;
      @(negedge clk_out); t1 = $realtime;
      @(posedge clk_out); t2 = $realtime;
      check((t2 - t0) > exp_period(s, k) - 0.01 && (t2 - t0) < exp_period(s, k) + 0.01,
            s ? "R1 R3 period osc" : "R1 R3 period pll", t2 - t0, exp_period(s, k));
      check((t1 - t0) > exp_high(s, k) - 0.01 && (t1 - t0) < exp_high(s, k) + 0.01,
            "R2 high time", t1 - t0, exp_high(s, k));
    end

    // R4: output off in both modes
    disable_and_config(0, 2, 1);
    check_low_for(60.0, "R4 off sync");
    disable_and_config(1, 1, 0);
    check_low_for(60.0, "R4 off async");

    // R6: asynchronous disable cuts the high phase at once
    disable_and_config(1, 3, 0);
    oe = 1;
    @(posedge clk_out); @(posedge clk_out);
    #0.5; oe = 0; #0.1;
    check(clk_out == 0, "R6 immediate off", real'(clk_out), 0.0);
    check_low_for(250.0, "R6 stays off");

    // R7: synchronous disable completes the high phase
    disable_and_config(0, 4, 1);
    oe = 1;
    @(posedge clk_out); @(posedge clk_out); t0 = $realtime;
    #0.5; oe = 0;
    @(negedge clk_out); t1 = $realtime;
    check((t1 - t0) > exp_high(0, 4) - 0.01 && (t1 - t0) < exp_high(0, 4) + 0.01,
          "R7 pulse completes", t1 - t0, exp_high(0, 4));
    check_low_for(200.0, "R7 no further pulse");

    // R10: synchronous power-down completes the high phase
    disable_and_config(1, 2, 1);
    oe = 1;
    @(posedge clk_out); @(posedge clk_out); t0 = $realtime;
    #0.5; pd = 1;
    @(negedge clk_out); t1 = $realtime;
    check((t1 - t0) > exp_high(1, 2) - 0.01 && (t1 - t0) < exp_high(1, 2) + 0.01,
          "R10 pd pulse completes", t1 - t0, exp_high(1, 2));
    check_low_for(150.0, "R5 pd holds low");
    pd = 0;

    // R5: restart phase after power-down in asynchronous mode
    disable_and_config(0, 3, 0);
    oe = 1; pd = 1;
    #20.3;
    check(clk_out == 0, "R5 pd low", real'(clk_out), 0.0);
    pd = 0;
    begin
      int n = 0;
      while (!clk_out && n < 50) begin
        @(posedge pll_clk); n++; #0.1;
      end
      check(n == 4, "R5 restart edges", real'(n), 4.0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule